// File: doc/BRIEF.md
# Round-Robin Typed-Port Instruction Issue Arbiter

This block is the issue stage of a compute unit that holds several schedulers, each owning a set of wavefront slots. Every slot presents one head instruction: a valid flag, a 3-bit kind code and a stall flag raised by the wait-counter logic. The schedulers are active one at a time, in strict rotation, one per clock. In its cycle the active scheduler picks at most one wavefront for each port kind and offers those picks to the execution ports. Each scheduler has a private vector-ALU port. The scalar, branch, vector-memory, local-memory and export ports are shared by all schedulers.

A slot holds a single head, so two picks in one cycle always come from two different wavefronts. No ordering is checked between instructions of one wavefront; the producer of the heads handles that. Wait-type heads never reach a port. The active scheduler retires them itself. Within a kind, a rotating pointer kept per scheduler and per kind selects the wavefront.

Every port is valid/ready. An offer is a combinational function of the heads and the arbiter state. It never depends on the port's ready. An offer lasts one cycle only. If it is not accepted, the instruction stays at its slot's head and can be offered again on that scheduler's next turn. The arbiter raises `wave_take` for a slot in the cycle that slot's head is consumed. The producer must then advance that head.

Top module: `isq_issue_arbiter`

## Requirements
- R1: While `rst_n` is low, no port is offered and no `wave_take` is raised. After release, scheduler 0 is active first and every pointer is 0.
- R2: The active scheduler advances 0, 1, …, NS-1, 0 by one every cycle, whether or not anything issues. Only the active scheduler's slots are looked at.
- R3: `valu_valid[s]` is raised only in scheduler s's cycle, so at most once every NS cycles. `valu_slot` field s carries the chosen slot.
- R4: Shared port k (0 scalar, 1 branch, 2 vector memory, 3 local memory, 4 export) carries `{scheduler, slot}` on `sh_wid` field k. The scheduler sits in the upper SW bits.
- R5: Kind codes are: 0 vector ALU, 1 scalar, 2 branch, 3 vector memory, 4 local memory, 5 export, 6 wait, 7 empty. Each port kind receives at most one pick per cycle.
- R6: A kind's search starts at that scheduler's pointer for the kind and wraps modulo NW. A transfer at slot i sets the pointer to i+1 (wrapping). With no transfer, the pointer is unchanged.
- R7: At most MAX_ISSUE (5) offers are made per cycle. Candidates keep priority in kind order 0 to 5, and the lowest-priority kinds beyond the limit are withheld.
- R8: A stalled slot is never picked and never taken. This also applies to a wait head.
- R9: Every valid, unstalled wait head of the active scheduler is taken in that cycle. No port is offered for it.
- R10: A head with kind 7 is never offered and never taken.
- R11: A head is taken exactly when its port transfers (valid and ready). An offer that is not accepted leaves the slot untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_valid | input | NS*NW | Head present, index s*NW+w |
| wave_op | input | NS*NW*3 | Head kind code, 3 bits per slot |
| wave_stall | input | NS*NW | Slot held by wait-counter logic |
| wave_take | output | NS*NW | Head consumed this cycle |
| valu_valid | output | NS | Private vector-ALU offer per scheduler |
| valu_ready | input | NS | Vector-ALU port accepts |
| valu_slot | output | NS*WW | Slot index per vector-ALU port |
| sh_valid | output | 5 | Shared port offers |
| sh_ready | input | 5 | Shared port accepts |
| sh_wid | output | 5*(SW+WW) | Scheduler and slot per shared port |

## Verification
The bench aims at dense cycles where all six port kinds have candidates at once. A cap in the wrong place would either push out six instructions or withhold the wrong kind. Pointer wrap at slot NW-1 and pointer behaviour under refused offers get heavy back-pressure sweeps. A design that advanced the pointer on an offer rather than on a transfer would skip a wavefront. Stalled wait heads, wait heads mixed with ported kinds, and empty-code heads are each driven in bulk. Retiring a stalled wait or taking an empty head would show up directly on `wave_take`.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [2:0] {
    OP_VALU   = 3'd0,
    OP_SALU   = 3'd1,
    OP_BRANCH = 3'd2,
    OP_VMEM   = 3'd3,
    OP_LDS    = 3'd4,
    OP_EXPORT = 3'd5,
    OP_WAIT   = 3'd6,
    OP_NONE   = 3'd7
  } op_kind_e;

  localparam int PORT_KINDS   = 6;
  localparam int SHARED_KINDS = PORT_KINDS - 1;
  localparam int OP_W         = 3;
endpackage

// File: rtl/isq_turn_ctr.sv
module isq_turn_ctr #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] turn
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  turn <= '0;
    else if (turn == W'(N - 1))  turn <= '0;
    else                         turn <= turn + 1'b1;
  end
endmodule

// File: rtl/isq_rr_pick.sv
module isq_rr_pick #(
  parameter int N  = 10,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);
  int j;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    j     = 0;
    for (int i = 0; i < N; i++) begin
      j = int'(ptr) + i;
      if (j >= N) j = j - N;
      if (!found && req[IW'(j)]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/isq_issue_cap.sv
module isq_issue_cap #(
  parameter int K    = 6,
  parameter int MAXI = 5
) (
  input  logic [K-1:0] cand,
  output logic [K-1:0] keep
);
  int cnt;
  always_comb begin
    cnt  = 0;
    keep = '0;
    for (int i = 0; i < K; i++) begin
      keep[i] = cand[i] && (cnt < MAXI);
      if (keep[i]) cnt = cnt + 1;
    end
  end
endmodule

// File: rtl/isq_issue_arbiter.sv
module isq_issue_arbiter
  import isq_pkg::*;
#(
  parameter int NS        = 4,
  parameter int NW        = 10,
  parameter int MAX_ISSUE = 5,
  localparam int SW  = (NS > 1) ? $clog2(NS) : 1,
  localparam int WW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int IDW = SW + WW,
  localparam int NSH = SHARED_KINDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NS*NW-1:0]      wave_valid,
  input  logic [NS*NW*OP_W-1:0] wave_op,
  input  logic [NS*NW-1:0]      wave_stall,
  output logic [NS*NW-1:0]      wave_take,
  output logic [NS-1:0]         valu_valid,
  input  logic [NS-1:0]         valu_ready,
  output logic [NS*WW-1:0]      valu_slot,
  output logic [NSH-1:0]        sh_valid,
  input  logic [NSH-1:0]        sh_ready,
  output logic [NSH*IDW-1:0]    sh_wid
);
  localparam int NK = PORT_KINDS;

  logic [SW-1:0]   turn;
  logic [NW-1:0]   act_valid, act_stall;
  logic [OP_W-1:0] act_op [NW];
  logic [NW-1:0]   req [NK];
  logic [WW-1:0]   ptr_q [NS][NK];
  logic [WW-1:0]   cur_ptr [NK];
  logic [WW-1:0]   pick_idx [NK];
  logic [NK-1:0]   cand, keep, offer, fire;

  isq_turn_ctr #(.N(NS), .W(SW)) u_turn (
    .clk   (clk),
    .rst_n (rst_n),
    .turn  (turn)
  );

  // Slice out the active scheduler's slots
  always_comb begin
    for (int w = 0; w < NW; w++) begin
      act_valid[w] = wave_valid[int'(turn)*NW + w];
      act_stall[w] = wave_stall[int'(turn)*NW + w];
      act_op[w]    = wave_op[(int'(turn)*NW + w)*OP_W +: OP_W];
    end
    for (int k = 0; k < NK; k++) cur_ptr[k] = ptr_q[turn][k];
  end

  for (genvar k = 0; k < NK; k++) begin : g_kind
    always_comb begin
      for (int w = 0; w < NW; w++)
        req[k][w] = act_valid[w] && !act_stall[w] && (act_op[w] == OP_W'(k));
    end

    isq_rr_pick #(.N(NW), .IW(WW)) u_pick (
      .req   (req[k]),
      .ptr   (cur_ptr[k]),
      .found (cand[k]),
      .idx   (pick_idx[k])
    );

    assign offer[k] = keep[k] & rst_n;

    if (k == 0) begin : g_priv
      assign fire[k] = offer[k] & valu_ready[turn];
    end else begin : g_shared
      assign fire[k]                        = offer[k] & sh_ready[k-1];
      assign sh_valid[k-1]                  = offer[k];
      assign sh_wid[(k-1)*IDW +: IDW]       = {turn, pick_idx[k]};
    end
  end

  isq_issue_cap #(.K(NK), .MAXI(MAX_ISSUE)) u_cap (
    .cand (cand),
    .keep (keep)
  );

  always_comb begin
    valu_valid       = '0;
    valu_valid[turn] = offer[0];
    for (int s = 0; s < NS; s++) valu_slot[s*WW +: WW] = pick_idx[0];
  end

  // Head consumption: ported transfer, or wait retired in the scheduler
  always_comb begin
    wave_take = '0;
    if (rst_n) begin
      for (int w = 0; w < NW; w++) begin
        if (act_valid[w] && !act_stall[w]) begin
          if (act_op[w] == OP_WAIT)
            wave_take[int'(turn)*NW + w] = 1'b1;
          else if (act_op[w] != OP_NONE && fire[int'(act_op[w])] &&
                   pick_idx[int'(act_op[w])] == WW'(w))
            wave_take[int'(turn)*NW + w] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < NK; k++) ptr_q[s][k] <= '0;
    end else begin
      for (int k = 0; k < NK; k++)
        if (fire[k])
          ptr_q[turn][k] <= (pick_idx[k] == WW'(NW - 1)) ? '0 : pick_idx[k] + 1'b1;
    end
  end
endmodule

// File: rtl/isq_issue_chk.sv
module isq_issue_chk
  import isq_pkg::*;
#(
  parameter int NS        = 4,
  parameter int NW        = 10,
  parameter int MAX_ISSUE = 5,
  localparam int SW  = (NS > 1) ? $clog2(NS) : 1,
  localparam int WW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int IDW = SW + WW,
  localparam int NSH = SHARED_KINDS
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NS*NW-1:0]      wave_valid,
  input logic [NS*NW*OP_W-1:0] wave_op,
  input logic [NS*NW-1:0]      wave_stall,
  input logic [NS*NW-1:0]      wave_take,
  input logic [NS-1:0]         valu_valid,
  input logic [NS-1:0]         valu_ready,
  input logic [NS*WW-1:0]      valu_slot,
  input logic [NSH-1:0]        sh_valid,
  input logic [NSH-1:0]        sh_ready,
  input logic [NSH*IDW-1:0]    sh_wid
);
  logic [7:0] gap [NS];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      if (!rst_n)              gap[s] <= 8'hFF;
      else if (valu_valid[s])  gap[s] <= 8'h00;
      else if (gap[s] != 8'hFF) gap[s] <= gap[s] + 8'h01;
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (valu_valid == '0 && sh_valid == '0 && wave_take == '0));

  a_r3_one_valu_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(valu_valid));

  a_r7_issue_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valu_valid) + $countones(sh_valid)) <= MAX_ISSUE);

  a_r8_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_take & wave_stall) == '0);

  a_r11_take_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_take & ~wave_valid) == '0);

  for (genvar s = 0; s < NS; s++) begin : g_sp
    a_r3_valu_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      valu_valid[s] |-> (gap[s] >= 8'(NS - 1)));
  end

  for (genvar k = 0; k < NSH; k++) begin : g_rot
    logic [SW-1:0] sch;
    assign sch = sh_wid[k*IDW + WW +: SW];
    a_r2_sched_rotates: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_valid[k] && $past(sh_valid[k])) |->
        (sch == (($past(sch) == SW'(NS - 1)) ? '0 : $past(sch) + 1'b1)));
  end
endmodule

bind isq_issue_arbiter isq_issue_chk #(.NS(NS), .NW(NW), .MAX_ISSUE(MAX_ISSUE)) u_chk (.*);

// File: tb/isq_issue_arbiter_tb.sv
module isq_issue_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, NW = 10, MAXI = 5;
  localparam int SW = 2, WW = 4, IDW = 6, NSH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*NW-1:0]   wave_valid = '0, wave_stall = '0;
  logic [NS*NW*3-1:0] wave_op = '0;
  logic [NS*NW-1:0]   wave_take;
  logic [NS-1:0]      valu_valid, valu_ready = '0;
  logic [NS*WW-1:0]   valu_slot;
  logic [NSH-1:0]     sh_valid, sh_ready = '0;
  logic [NSH*IDW-1:0] sh_wid;

  always #(CLK_PERIOD/2) clk = ~clk;

  isq_issue_arbiter #(.NS(NS), .NW(NW), .MAX_ISSUE(MAXI)) dut_i (
    .clk, .rst_n, .wave_valid, .wave_op, .wave_stall, .wave_take,
    .valu_valid, .valu_ready, .valu_slot, .sh_valid, .sh_ready, .sh_wid
  );

  int checks = 0, errors = 0;
  int m_turn;
  int m_ptr [NS][6];
  bit bv [NS][NW];
  bit bst [NS][NW];
  int bop [NS][NW];

  task automatic chk(string tag, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // mode: 0 mixed, 1 all kinds dense, 2 wait heavy, 3 empty-code heavy
  task automatic gen(int mode, int p_stall, int p_ready);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        bv[s][w]  = (mode == 1) ? 1'b1 : (($urandom % 100) < 75);
        bst[s][w] = (mode == 1) ? 1'b0 : (($urandom % 100) < p_stall);
        case (mode)
          1: bop[s][w] = (w + int'($urandom % 2)) % 6;
          2: bop[s][w] = (($urandom % 100) < 60) ? 6 : int'($urandom % 6);
          3: bop[s][w] = (($urandom % 100) < 50) ? 7 : int'($urandom % 8);
          default: bop[s][w] = int'($urandom % 8);
        endcase
        wave_valid[s*NW+w]   = bv[s][w];
        wave_stall[s*NW+w]   = bst[s][w];
        wave_op[(s*NW+w)*3 +: 3] = 3'(bop[s][w]);
      end
    for (int s = 0; s < NS; s++) valu_ready[s] = (($urandom % 100) < p_ready);
    for (int k = 0; k < NSH; k++) sh_ready[k] = (($urandom % 100) < p_ready);
  endtask

  task automatic check_cycle(string tag);
    int cidx [6];
    bit cand [6];
    bit keep [6];
    bit fire [6];
    int cnt;
    logic [NS-1:0] ev;
    logic [NSH-1:0] esv;
    logic [NS*NW-1:0] et;
    for (int k = 0; k < 6; k++) begin
      cand[k] = 0; cidx[k] = 0;
      for (int i = 0; i < NW; i++) begin
        int w;
        w = (m_ptr[m_turn][k] + i) % NW;
        if (!cand[k] && bv[m_turn][w] && !bst[m_turn][w] && bop[m_turn][w] == k) begin
          cand[k] = 1; cidx[k] = w;
        end
      end
    end
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      keep[k] = cand[k] && cnt < MAXI;
      if (keep[k]) cnt++;
    end
    ev = '0; ev[m_turn] = keep[0];
    chk({tag, " R3"}, "valu_valid", longint'(valu_valid), longint'(ev));
    if (keep[0]) chk({tag, " R3"}, "valu_slot", longint'(valu_slot[m_turn*WW +: WW]), cidx[0]);
    for (int k = 0; k < NSH; k++) esv[k] = keep[k+1];
    chk({tag, " R4 R7"}, "sh_valid", longint'(sh_valid), longint'(esv));
    for (int k = 0; k < NSH; k++)
      if (keep[k+1]) chk({tag, " R4"}, "sh_wid", longint'(sh_wid[k*IDW +: IDW]), m_turn*16 + cidx[k+1]);
    fire[0] = keep[0] && valu_ready[m_turn];
    for (int k = 1; k < 6; k++) fire[k] = keep[k] && sh_ready[k-1];
    et = '0;
    for (int w = 0; w < NW; w++) begin
      int op;
      op = bop[m_turn][w];
      if (bv[m_turn][w] && !bst[m_turn][w] &&
          (op == 6 || (op < 6 && fire[op] && cidx[op] == w)))
        et[m_turn*NW + w] = 1'b1;
    end
    chk({tag, " R11"}, "wave_take", longint'(wave_take), longint'(et));
    for (int k = 0; k < 6; k++)
      if (fire[k]) m_ptr[m_turn][k] = (cidx[k] + 1) % NW;
    m_turn = (m_turn + 1) % NS;
  endtask

  task automatic run(string tag, int n, int mode, int p_stall, int p_ready);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      gen(mode, p_stall, p_ready);
      #1;
      check_cycle(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset keeps every port quiet even with busy heads
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      gen(0, 10, 100);
      #1;
      chk("R1", "valu_valid", longint'(valu_valid), 0);
      chk("R1", "sh_valid", longint'(sh_valid), 0);
      chk("R1", "wave_take", longint'(wave_take), 0);
    end
    m_turn = 0;
    for (int s = 0; s < NS; s++) for (int k = 0; k < 6; k++) m_ptr[s][k] = 0;
    @(negedge clk);
    rst_n = 1'b1;
    gen(0, 10, 100);
    #1;
    check_cycle("R1 R2");
    run("R2 R5 R6", 400, 0, 10, 100);
    run("R7", 200, 1, 0, 100);
    run("R8", 200, 0, 50, 100);
    run("R9", 200, 2, 30, 100);
    run("R10", 200, 3, 10, 100);
    run("R11 R6", 400, 0, 10, 40);
    run("R7 R11", 200, 1, 0, 60);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule